// File: doc/BRIEF.md
# Transmit ring command interpreter

This block empties a circular transmit ring in memory. The host writes eight-byte entries into the ring and moves a producer pointer forward. The block owns the consumer pointer. It fetches each entry that lies between the two pointers and then works through the entry's four lanes in order, lane 0 first.

Each lane pairs one data byte with one control byte. The control byte selects one of four actions:
- skip the lane;
- hand the data byte to a UART transmitter over a ready/valid stream;
- load the data byte into the modem-control output;
- stall for as many milliseconds as the data byte states.

The control byte can also ask for a one-cycle completion pulse once its lane has finished.

The host steers the engine with five inputs: run, channel reset, pause, flow-control enable and the CTS line. Two status outputs report the delay timer and whether a pause has taken hold. The block pulses an event each time the consumer pointer catches up with the producer pointer.

Top module: `tx_ring_engine`

## Requirements
- R1: An entry is 64 bits. Data byte i sits at bits 8i+7..8i. Its control byte sits at bits 32+8i+7..32+8i. Lanes are processed in the order 0, 1, 2, 3, so transmitted bytes leave in lane order.
- R2: A control code of 01 in bits 7:6 presents the lane's data byte on `tx_data` with `tx_valid` high. `tx_valid` and `tx_data` stay unchanged until `tx_ready` is seen high, and each byte is transferred exactly once.
- R3: A control code of 10 copies the data byte to `mcr_out` and pulses `mcr_load` for one cycle.
- R4: A control code of 11 with data value N > 0 holds `delay_busy` high for exactly N × (CLK_HZ/1000) cycles. Nothing is sent or loaded during that time. A value of 0 completes at once and never raises `delay_busy`.
- R5: A control code of 00 produces no byte, no modem-control load and no delay.
- R6: Bit 5 of a control byte produces one `ev_tx_done` pulse after that lane's action has completed, for any control code. Without bit 5 no pulse is produced.
- R7: While `ctl_flow_en` is high and `cts` is low, `tx_valid` stays low. A pending byte is sent once `cts` returns high.
- R8: While `ctl_pause` is high, no new entry is fetched and no new lane is started. `paused` rises only at a lane boundary, never while a delay or a byte handoff is under way. While `paused` is high there is no transmit activity.
- R9: `ctl_reset` abandons the current entry and stops any delay. `tx_valid` and `delay_busy` are low in the cycle that follows. The consumer pointer keeps its value.
- R10: Fetching starts only while `ctl_run` is high and the consumer pointer differs from the producer pointer. The consumer pointer advances by 8, modulo 2^RING_AW, only after all four lanes of an entry are done.
- R11: `ev_tx_empty` pulses once when the consumer pointer advances to a value equal to the producer pointer.
- R12: After `rst`:
  - `cons_ptr` is 0;
  - `mcr_out` is 0;
  - `tx_valid`, `mcr_load`, `delay_busy`, `ev_tx_done` and `ev_tx_empty` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_run | input | 1 | Allows entries to be fetched |
| ctl_reset | input | 1 | Idles the channel and aborts the current entry |
| ctl_pause | input | 1 | Requests a halt at the next lane boundary |
| ctl_flow_en | input | 1 | Gates transmission with CTS |
| cts | input | 1 | Clear-to-send, active high |
| prod_ptr | input | RING_AW | Producer byte offset written by the host |
| cons_ptr | output | RING_AW | Consumer byte offset owned by the block |
| mem_rd_en | output | 1 | Entry read strobe |
| mem_rd_addr | output | RING_AW-3 | Entry index being read |
| mem_rd_data | input | 64 | Entry contents, valid one cycle after the strobe |
| tx_data | output | 8 | Byte to the transmitter |
| tx_valid | output | 1 | Byte offered |
| tx_ready | input | 1 | Transmitter accepts the byte |
| mcr_out | output | 8 | Modem-control value |
| mcr_load | output | 1 | One-cycle pulse when `mcr_out` is written |
| delay_busy | output | 1 | A millisecond delay is running |
| paused | output | 1 | The pause request has taken hold |
| ev_tx_done | output | 1 | Lane completion event |
| ev_tx_empty | output | 1 | Ring drained event |

## Verification
If the lane index or the latched entry goes wrong, the bytes on the transmit stream come out in the wrong order or with the wrong values. That shows within the same entry, before the empty event for that entry. If the prescaler or the millisecond count is off, the number of cycles with `delay_busy` high no longer equals N times the per-millisecond count, so a single delay entry exposes it. If the consumer pointer is mishandled, whether in the step, the wrap or the reset hold, the block either refetches or skips entries. That shows as a missing or repeated empty event and as a wrong `cons_ptr`, no later than the next entry.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;

    localparam int LANES        = 4;
    localparam int LANE_W       = 2;
    localparam int ENTRY_BYTES  = 8;
    localparam int ENTRY_SHIFT  = 3;

    typedef enum logic [1:0] {
        OP_SKIP = 2'b00,
        OP_SEND = 2'b01,
        OP_MCR  = 2'b10,
        OP_WAIT = 2'b11
    } lane_op_e;

    typedef struct packed {
        lane_op_e    op;
        logic        done_req;
        logic [4:0]  spare;
    } lane_ctl_t;

    typedef struct packed {
        logic [LANES-1:0][7:0] ctl;
        logic [LANES-1:0][7:0] data;
    } ring_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LANE,
        ST_SEND,
        ST_DELAY,
        ST_ADV
    } eng_state_e;

    function automatic lane_ctl_t decode_ctl(input logic [7:0] raw);
        return lane_ctl_t'(raw);
    endfunction

endpackage

// File: rtl/tx_entry_buf.sv
module tx_entry_buf
    import tx_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [63:0]       din,
    input  logic [LANE_W-1:0] lane,
    output lane_ctl_t         ctl,
    output logic [7:0]        data
);
    ring_entry_t ent_q;

    always_ff @(posedge clk) begin
        if (rst)       ent_q <= '0;
        else if (load) ent_q <= ring_entry_t'(din);
    end

    assign ctl  = decode_ctl(ent_q.ctl[lane]);
    assign data = ent_q.data[lane];
endmodule

// File: rtl/tx_ms_timer.sv
module tx_ms_timer #(
    parameter int CYC_PER_MS = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       start,
    input  logic [7:0] ms_val,
    output logic       busy,
    output logic       done
);
    localparam int PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [PW-1:0] PRESC_LAST = PW'(CYC_PER_MS - 1);

    logic [PW-1:0] presc_q;
    logic [7:0]    ms_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            ms_q    <= '0;
            presc_q <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy    <= 1'b1;
                ms_q    <= ms_val;
                presc_q <= '0;
            end else if (busy) begin
                if (presc_q == PRESC_LAST) begin
                    presc_q <= '0;
                    if (ms_q == 8'd1) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        ms_q <= ms_q - 8'd1;
                    end
                end else begin
                    presc_q <= presc_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
    import tx_ring_pkg::*;
#(
    parameter int RING_AW = 12,
    parameter int CLK_HZ  = 250_000_000
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ctl_run,
    input  logic                           ctl_reset,
    input  logic                           ctl_pause,
    input  logic                           ctl_flow_en,
    input  logic                           cts,
    input  logic [RING_AW-1:0]             prod_ptr,
    output logic [RING_AW-1:0]             cons_ptr,
    output logic                           mem_rd_en,
    output logic [RING_AW-ENTRY_SHIFT-1:0] mem_rd_addr,
    input  logic [63:0]                    mem_rd_data,
    output logic [7:0]                     tx_data,
    output logic                           tx_valid,
    input  logic                           tx_ready,
    output logic [7:0]                     mcr_out,
    output logic                           mcr_load,
    output logic                           delay_busy,
    output logic                           paused,
    output logic                           ev_tx_done,
    output logic                           ev_tx_empty
);
    localparam int CYC_PER_MS = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
    localparam logic [RING_AW-1:0] PTR_STEP = RING_AW'(ENTRY_BYTES);
    localparam logic [LANE_W-1:0]  LAST_LANE = LANE_W'(LANES - 1);

    eng_state_e        st_q, st_d;
    logic [LANE_W-1:0] lane_q;
    logic [RING_AW-1:0] cons_q;
    logic [RING_AW-1:0] cons_next;
    lane_ctl_t         cur_ctl;
    logic [7:0]        cur_data;
    logic              load_entry, rd_go, finish, start_tmr, mcr_go;
    logic              tmr_busy, tmr_done;
    logic              cts_block, lane_last;

    tx_entry_buf u_buf (
        .clk  (clk),
        .rst  (rst),
        .load (load_entry),
        .din  (mem_rd_data),
        .lane (lane_q),
        .ctl  (cur_ctl),
        .data (cur_data)
    );

    tx_ms_timer #(.CYC_PER_MS(CYC_PER_MS)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .clear  (ctl_reset),
        .start  (start_tmr),
        .ms_val (cur_data),
        .busy   (tmr_busy),
        .done   (tmr_done)
    );

    assign cts_block = ctl_flow_en && !cts;
    assign lane_last = (lane_q == LAST_LANE);
    assign cons_next = cons_q + PTR_STEP;

    always_comb begin
        st_d       = st_q;
        rd_go      = 1'b0;
        load_entry = 1'b0;
        finish     = 1'b0;
        start_tmr  = 1'b0;
        mcr_go     = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (ctl_run && !ctl_pause && (cons_q != prod_ptr)) begin
                    rd_go = 1'b1;
                    st_d  = ST_FETCH;
                end
            end
            ST_FETCH: begin
                load_entry = 1'b1;
                st_d       = ST_LANE;
            end
            ST_LANE: begin
                if (!ctl_pause) begin
                    case (cur_ctl.op)
                        OP_SKIP: finish = 1'b1;
                        OP_SEND: st_d = ST_SEND;
                        OP_MCR: begin
                            mcr_go = 1'b1;
                            finish = 1'b1;
                        end
                        OP_WAIT: begin
                            if (cur_data == 8'd0) begin
                                finish = 1'b1;
                            end else begin
                                start_tmr = 1'b1;
                                st_d      = ST_DELAY;
                            end
                        end
                        default: finish = 1'b1;
                    endcase
                end
            end
            ST_SEND:  if (tx_ready && !cts_block) finish = 1'b1;
            ST_DELAY: if (tmr_done) finish = 1'b1;
            ST_ADV:   st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
        if (finish) st_d = lane_last ? ST_ADV : ST_LANE;
        if (ctl_reset) begin
            st_d      = ST_IDLE;
            rd_go     = 1'b0;
            finish    = 1'b0;
            start_tmr = 1'b0;
            mcr_go    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            lane_q      <= '0;
            cons_q      <= '0;
            mcr_out     <= '0;
            mcr_load    <= 1'b0;
            ev_tx_done  <= 1'b0;
            ev_tx_empty <= 1'b0;
        end else begin
            st_q        <= st_d;
            mcr_load    <= mcr_go;
            ev_tx_done  <= finish && cur_ctl.done_req;
            ev_tx_empty <= 1'b0;
            if (mcr_go) mcr_out <= cur_data;
            if (load_entry)                lane_q <= '0;
            else if (finish && !lane_last) lane_q <= lane_q + 1'b1;
            if (st_q == ST_ADV && !ctl_reset) begin
                cons_q      <= cons_next;
                ev_tx_empty <= (cons_next == prod_ptr);
            end
        end
    end

    assign cons_ptr    = cons_q;
    assign mem_rd_en   = rd_go;
    assign mem_rd_addr = cons_q[RING_AW-1:ENTRY_SHIFT];
    assign tx_valid    = (st_q == ST_SEND) && !cts_block;
    assign tx_data     = cur_data;
    assign delay_busy  = tmr_busy;
    assign paused      = ctl_pause && ((st_q == ST_IDLE) || (st_q == ST_LANE));
endmodule

// File: rtl/tx_ring_engine_chk.sv
module tx_ring_engine_chk #(
    parameter int RING_AW = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               ctl_reset,
    input logic               ctl_flow_en,
    input logic               cts,
    input logic [RING_AW-1:0] prod_ptr,
    input logic [RING_AW-1:0] cons_ptr,
    input logic [7:0]         tx_data,
    input logic               tx_valid,
    input logic               tx_ready,
    input logic               mcr_load,
    input logic               delay_busy,
    input logic               paused,
    input logic               ev_tx_empty
);
    localparam logic [RING_AW-1:0] STEP = RING_AW'(8);

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst || ctl_reset)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));           // R2

    AST_CTS_GATE: assert property (@(posedge clk) disable iff (rst)
        (ctl_flow_en && !cts) |-> !tx_valid);                                  // R7

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (cons_ptr != $past(cons_ptr)) |-> (cons_ptr == $past(cons_ptr) + STEP)); // R10

    AST_DELAY_QUIET: assert property (@(posedge clk) disable iff (rst)
        delay_busy |-> (!tx_valid && !mcr_load));                              // R4

    AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
        paused |-> (!tx_valid && !delay_busy));                                // R8

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        ctl_reset |=> (!tx_valid && !delay_busy && !mcr_load));                // R9

    AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (rst)
        (ev_tx_empty && $stable(prod_ptr)) |-> (cons_ptr == prod_ptr));        // R11
endmodule

bind tx_ring_engine tx_ring_engine_chk #(.RING_AW(RING_AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_reset   (ctl_reset),
    .ctl_flow_en (ctl_flow_en),
    .cts         (cts),
    .prod_ptr    (prod_ptr),
    .cons_ptr    (cons_ptr),
    .tx_data     (tx_data),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .mcr_load    (mcr_load),
    .delay_busy  (delay_busy),
    .paused      (paused),
    .ev_tx_empty (ev_tx_empty)
);

// File: tb/sim_tx_ring_engine.sv
module sim_tx_ring_engine;
    localparam int AW  = 5;
    localparam int CLK = 4000;
    localparam int CPM = 4;
    localparam int NV  = 6;

    localparam logic [63:0] VEC [NV] = '{
        64'h40404040_44332211,
        64'hC0608000_03770B55,
        64'hA04020E0_039AFF00,
        64'h00000000_AAAAAAAA,
        64'h40C06040_5A02FF00,
        64'h40008080_0199021F
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1;
    logic          ctl_run = 1'b0, ctl_reset = 1'b0, ctl_pause = 1'b0;
    logic          ctl_flow_en = 1'b0, cts = 1'b1;
    logic [AW-1:0] prod_ptr = '0;
    logic [AW-1:0] cons_ptr;
    logic          mem_rd_en;
    logic [AW-4:0] mem_rd_addr;
    logic [63:0]   mem_rd_data = '0;
    logic [7:0]    tx_data;
    logic          tx_valid;
    logic          tx_ready = 1'b1;
    logic [7:0]    mcr_out;
    logic          mcr_load, delay_busy, paused, ev_tx_done, ev_tx_empty;

    tx_ring_engine #(.RING_AW(AW), .CLK_HZ(CLK)) u0 (
        .clk(clk), .rst(rst), .ctl_run(ctl_run), .ctl_reset(ctl_reset),
        .ctl_pause(ctl_pause), .ctl_flow_en(ctl_flow_en), .cts(cts),
        .prod_ptr(prod_ptr), .cons_ptr(cons_ptr), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .mcr_out(mcr_out), .mcr_load(mcr_load), .delay_busy(delay_busy),
        .paused(paused), .ev_tx_done(ev_tx_done), .ev_tx_empty(ev_tx_empty)
    );

    logic [63:0] mem [4];
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

    int  nchk = 0, nerr = 0;
    bit  fin = 1'b0;
    bit  ready_mode = 1'b0;
    int  rc = 0;

    initial forever begin
        @(posedge clk); #1;
        rc++;
        tx_ready <= ready_mode ? (rc % 3 != 0) : 1'b1;
    end

    logic [7:0] tx_log [16];
    int tx_n, txv_cyc, mcr_n, done_cnt, empty_cnt, busy_cyc;
    logic [7:0] mcr_last;

    always @(negedge clk) begin
        if (!rst) begin
            if (tx_valid && tx_ready) begin
                if (tx_n < 16) tx_log[tx_n] = tx_data;
                tx_n++;
            end
            if (tx_valid)    txv_cyc++;
            if (mcr_load)    begin mcr_n++; mcr_last = mcr_out; end
            if (ev_tx_done)  done_cnt++;
            if (ev_tx_empty) empty_cnt++;
            if (delay_busy)  busy_cyc++;
        end
    end

    task automatic clear_logs();
        tx_n = 0; txv_cyc = 0; mcr_n = 0; done_cnt = 0; empty_cnt = 0; busy_cyc = 0;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
    endtask

    task automatic push(input logic [63:0] v);
        mem[prod_ptr[AW-1:3]] = v;
        prod_ptr = prod_ptr + AW'(8);
    endtask

    task automatic wait_empty(input int lim);
        for (int k = 0; k < lim && empty_cnt == 0; k++) begin @(posedge clk); #1; end
    endtask

    task automatic model(input logic [63:0] v, input logic [7:0] mprev,
                         output int ns, output logic [31:0] eb, output int nd,
                         output int nm, output logic [7:0] lm, output int bz);
        ns = 0; nd = 0; nm = 0; lm = mprev; bz = 0; eb = '0;
        for (int i = 0; i < 4; i++) begin
            logic [7:0] c, d;
            c = v[32 + 8*i +: 8];
            d = v[8*i +: 8];
            case (c[7:6])
                2'b01: begin eb[8*ns +: 8] = d; ns++; end
                2'b10: begin nm++; lm = d; end
                2'b11: bz += int'(d) * CPM;
                default: ;
            endcase
            if (c[5]) nd++;
        end
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        clear_logs();
        cyc(1);
        // R12: reset state
        chk("R12", "cons_ptr", 32'(cons_ptr), 0);
        chk("R12", "mcr_out", 32'(mcr_out), 0);
        chk("R12", "tx_valid", 32'(tx_valid), 0);
        chk("R12", "delay_busy", 32'(delay_busy), 0);
        chk("R12", "events", 32'({mcr_load, ev_tx_done, ev_tx_empty}), 0);

        // R10: nothing is fetched while run is low
        push(64'h00000040_000000EE);
        cyc(12);
        chk("R10", "no fetch while stopped", 32'(tx_n), 0);
        chk("R10", "cons held while stopped", 32'(cons_ptr), 0);
        ctl_run = 1'b1;
        wait_empty(100);
        chk("R10", "byte after run", 32'(tx_log[0]), 32'hEE);
        chk("R10", "cons after first entry", 32'(cons_ptr), 8);

        // Vector table, with backpressure on the stream
        ready_mode = 1'b1;
        for (int v = 0; v < NV; v++) begin
            int ns, nd, nm, bz;
            logic [31:0] eb;
            logic [7:0] lm, mprev;
            logic [AW-1:0] exp_ptr;
            mprev = mcr_out;
            model(VEC[v], mprev, ns, eb, nd, nm, lm, bz);
            clear_logs();
            push(VEC[v]);
            exp_ptr = prod_ptr;
            wait_empty(400);
            cyc(2);
            chk("R2", "bytes sent", 32'(tx_n), 32'(ns));
            for (int k = 0; k < ns && k < 4; k++)
                chk("R1", "lane order byte", 32'(tx_log[k]), 32'(eb[8*k +: 8]));
            chk("R3", "mcr loads", 32'(mcr_n), 32'(nm));
            chk("R3", "mcr value", 32'(mcr_out), 32'(lm));
            chk("R4", "delay cycles", 32'(busy_cyc), 32'(bz));
            chk("R6", "done events", 32'(done_cnt), 32'(nd));
            chk("R10", "cons step/wrap", 32'(cons_ptr), 32'(exp_ptr));
            chk("R11", "empty events", 32'(empty_cnt), 1);
            if (v == 3) chk("R5", "skip-only activity", 32'(tx_n + mcr_n + busy_cyc), 0);
        end
        ready_mode = 1'b0;

        // R7: flow control holds a byte until CTS returns
        clear_logs();
        ctl_flow_en = 1'b1;
        cts = 1'b0;
        push(64'h00000060_0000003C);
        cyc(20);
        chk("R7", "valid while CTS low", 32'(txv_cyc), 0);
        chk("R7", "bytes while CTS low", 32'(tx_n), 0);
        cts = 1'b1;
        wait_empty(100);
        chk("R7", "byte after CTS", 32'(tx_log[0]), 32'h3C);
        chk("R6", "done after send", 32'(done_cnt), 1);
        ctl_flow_en = 1'b0;

        // R8: pause blocks fetch, and takes hold only at a lane boundary
        begin
            logic [AW-1:0] old;
            int bad;
            clear_logs();
            old = cons_ptr;
            ctl_pause = 1'b1;
            push(64'h000040C0_0000A505);
            cyc(15);
            chk("R8", "no fetch when paused", 32'(busy_cyc + tx_n), 0);
            chk("R8", "cons held when paused", 32'(cons_ptr), 32'(old));
            chk("R8", "paused flag in idle", 32'(paused), 1);
            ctl_pause = 1'b0;
            for (int k = 0; k < 50 && !delay_busy; k++) cyc(1);
            ctl_pause = 1'b1;
            bad = 0;
            for (int k = 0; k < 100 && delay_busy; k++) begin
                if (paused) bad++;
                cyc(1);
            end
            chk("R8", "paused during delay", 32'(bad), 0);
            cyc(4);
            chk("R8", "paused at boundary", 32'(paused), 1);
            cyc(10);
            chk("R8", "no send while paused", 32'(txv_cyc), 0);
            ctl_pause = 1'b0;
            wait_empty(100);
            chk("R8", "send after resume", 32'(tx_log[0]), 32'hA5);
            chk("R4", "delay length", 32'(busy_cyc), 32'(5 * CPM));
        end

        // R9: channel reset aborts a running delay
        begin
            logic [AW-1:0] old;
            clear_logs();
            push(64'h000040C0_00007728);
            for (int k = 0; k < 50 && !delay_busy; k++) cyc(1);
            old = cons_ptr;
            ctl_reset = 1'b1;
            prod_ptr = cons_ptr;
            cyc(1);
            chk("R9", "busy after reset", 32'(delay_busy), 0);
            chk("R9", "valid after reset", 32'(tx_valid), 0);
            cyc(1);
            ctl_reset = 1'b0;
            cyc(30);
            chk("R9", "no send after reset", 32'(tx_n), 0);
            chk("R9", "cons kept", 32'(cons_ptr), 32'(old));
            chk("R11", "no empty event", 32'(empty_cnt), 0);
        end

        fin = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int k = 0; k < 150000; k++) @(posedge clk);
        if (!fin) begin
            nchk++;
            nerr++;
            $display("FAIL R10 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule